// File: doc/BRIEF.md
# Single-Accumulator Processor with Interrupt Check

This block is a small multi-cycle processor built around one accumulator. It reads 16-bit instruction words from a synchronous, single-port, word-addressed memory of 4096 words. Every instruction goes through a fetch stage and then an execute stage. The upper four bits of the instruction select the operation. The lower twelve bits give a direct memory address. Data words are sign-magnitude integers: bit 15 is the sign and bits 14..0 are the magnitude. All memory traffic passes through an internal address register and an internal buffer register. The program counter and the accumulator never drive the bus directly.

The memory returns read data one cycle after it sees an address. Because of this, both stages take two or three cycles, and every instruction takes exactly five clock cycles. When an execute stage finishes, the processor looks at its interrupt request input. If the enable bit in the status word is set, it stores the program counter, clears the enable bit and continues fetching at a fixed vector. A return instruction restores the saved program counter and sets the enable bit again. A halt instruction stops the processor for good.

The status word appears on an output. It carries the enable bit and the three condition flags that the add operation updates.

Top module: `acc_cpu`

## Requirements
- R1: After reset the program counter is RESET_PC (default 0x300) and the memory address output shows it. The status output `psw` = {ie, ovf, neg, zero} reads 4'b1000. `halted` and `mem_we` are low.
- R2: Each instruction takes five cycles. The fetch reads the word at the program counter, and the program counter then advances by one.
- R3: Opcode 4'b0001 (bits 15..12) loads the accumulator from the word at the address in bits 11..0.
- R4: Opcode 4'b0010 writes the accumulator to the addressed word, with `mem_we` high for exactly one cycle.
- R5: Opcode 4'b0101 adds the addressed word to the accumulator in sign-magnitude form and leaves the sum in the accumulator. A zero result always has a positive sign (bit 15 = 0).
- R6: Only add updates the flags: zero when the result magnitude is 0, neg when the result sign is 1, and ovf when the magnitude sum carries out of 15 bits. In that case the low 15 bits are kept. Load, store and no-op leave the flags unchanged.
- R7: At the end of an execute stage, if `irq` is high and ie = 1, the program counter is saved, ie is cleared and the next fetch comes from VECTOR (default 0xFF0).
- R8: While ie = 0, `irq` has no effect and the next fetch comes from the following address.
- R9: Opcode 4'b1111 restores the saved program counter and sets ie. The interrupt check at the end of that instruction uses the old ie, so at least one instruction of the resumed program runs before the next entry.
- R10: Opcode 4'b0000 raises `halted` permanently. After that there are no more writes, and `irq` is ignored.
- R11: All other opcodes are no-ops: the accumulator and the flags are unchanged, and no write happens.
- R12: The program 0x1940, 0x5941, 0x2941 at 0x300, with 3 at 0x940 and 2 at 0x941, leaves 5 at 0x941 and the program counter at 0x303, so the next instruction is fetched from 0x303.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| irq | input | 1 | Interrupt request, level sensitive |
| halted | output | 1 | High once a halt instruction has executed |
| psw | output | 4 | Status word {ie, ovf, neg, zero} |

## Verification
On every cycle, the assertions check the following:
- written data always equals the accumulator;
- a halted processor stays halted and silent;
- the program counter advances during fetch;
- a zero flag never comes with a negative flag;
- interrupt entry saves the right program counter and jumps to the vector;
- with interrupts masked, the program counter does not move during execute.

Some behaviour only the bench scenarios can show:
- the arithmetic result of sign-magnitude sums, including overflow wrap and the negative-zero cases;
- flags surviving loads and no-ops;
- the one-instruction gap after a return while `irq` stays high;
- the cycle count of whole programs.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_PC = 12'h300,
  parameter logic [AW-1:0] VECTOR = 12'hFF0,
  parameter bit IE_AT_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  input  logic          irq,
  output logic          halted,
  output logic [3:0]    psw
);
  localparam int OPW = DW - AW;
  localparam int MW  = DW - 1;
  localparam logic [OPW-1:0] OP_HALT  = OPW'(0);
  localparam logic [OPW-1:0] OP_LOAD  = OPW'(1);
  localparam logic [OPW-1:0] OP_STORE = OPW'(2);
  localparam logic [OPW-1:0] OP_ADD   = OPW'(5);
  localparam logic [OPW-1:0] OP_RETI  = {OPW{1'b1}};

  typedef enum logic [2:0] {S_F1, S_F2, S_F3, S_E1, S_E2, S_HALT} state_t;

  state_t        state;
  logic [AW-1:0] pc, mar, epc;
  logic [DW-1:0] mbr, ir, acc;
  logic          ie, fz, fn, fv;
  logic [OPW-1:0] op;

  assign op        = ir[DW-1:AW];
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (state == S_E2) && (op == OP_STORE);
  assign halted    = (state == S_HALT);
  assign psw       = {ie, fv, fn, fz};

  logic          sa, sb, rsign, rovf;
  logic [MW-1:0] ma, mb, rmag;
  logic [MW:0]   usum;

  always_comb begin
    sa   = acc[MW];
    ma   = acc[MW-1:0];
    sb   = mem_rdata[MW];
    mb   = mem_rdata[MW-1:0];
    usum = {1'b0, ma} + {1'b0, mb};
    rovf = 1'b0;
    if (sa == sb) begin
      rmag  = usum[MW-1:0];
      rovf  = usum[MW];
      rsign = sa;
    end else if (ma >= mb) begin
      rmag  = ma - mb;
      rsign = sa;
    end else begin
      rmag  = mb - ma;
      rsign = sb;
    end
    if (rmag == '0) rsign = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_F1;
      pc    <= RESET_PC;
      mar   <= RESET_PC;
      epc   <= '0;
      mbr   <= '0;
      ir    <= '0;
      acc   <= '0;
      ie    <= IE_AT_RESET;
      fz    <= 1'b0;
      fn    <= 1'b0;
      fv    <= 1'b0;
    end else begin
      case (state)
        S_F1: begin
          mar   <= pc;
          state <= S_F2;
        end
        S_F2: begin
          pc    <= pc + 1'b1;
          state <= S_F3;
        end
        S_F3: begin
          ir    <= mem_rdata;
          mbr   <= mem_rdata;
          mar   <= mem_rdata[AW-1:0];
          state <= S_E1;
        end
        S_E1: begin
          if (op == OP_STORE) mbr <= acc;
          state <= S_E2;
        end
        S_E2: begin
          case (op)
            OP_LOAD: begin
              acc <= mem_rdata;
              mbr <= mem_rdata;
            end
            OP_ADD: begin
              acc <= {rsign, rmag};
              mbr <= mem_rdata;
              fz  <= (rmag == '0);
              fn  <= rsign;
              fv  <= rovf;
            end
            OP_RETI: begin
              pc <= epc;
              ie <= 1'b1;
            end
            default: ;
          endcase
          if (op == OP_HALT) begin
            state <= S_HALT;
          end else if (irq && ie) begin
            epc   <= pc;
            pc    <= VECTOR;
            ie    <= 1'b0;
            state <= S_F1;
          end else begin
            state <= S_F1;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end

  AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata == acc); // R4

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we)); // R10

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_F3) |-> pc == $past(pc) + 1'b1); // R2

  AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fz |-> !fn); // R5

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_E2 && $past(irq && ie) && $past(op) != OP_HALT)
      |-> (pc == VECTOR && !ie && epc == $past(pc))); // R7

  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_E2 && !ie && op != OP_RETI && op != OP_HALT)
      |=> (state == S_F1 && pc == $past(pc))); // R8
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_we;
  logic        irq = 1'b0;
  logic        halted;
  logic [3:0]  psw;

  logic [15:0] mem [0:4095];
  int          wr_count;
  int          n_checks = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .irq(irq), .halted(halted), .psw(psw)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] sm_add(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] s;
    logic [14:0] m;
    logic sg, v;
    v = 1'b0;
    if (a[15] == b[15]) begin
      s  = {1'b0, a[14:0]} + {1'b0, b[14:0]};
      m  = s[14:0];
      v  = s[15];
      sg = a[15];
    end else if (a[14:0] >= b[14:0]) begin
      m  = a[14:0] - b[14:0];
      sg = a[15];
    end else begin
      m  = b[14:0] - a[14:0];
      sg = b[15];
    end
    if (m == 15'd0) sg = 1'b0;
    return {v, sg, (m == 15'd0), sg, m};
  endfunction

  task automatic start();
    rst_n = 1'b0;
    irq = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    wr_count = 0;
    @(negedge clk);
  endtask

  task automatic run(output int edges);
    edges = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!halted && edges < 1000) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic add_case(input logic [15:0] a, input logic [15:0] b);
    logic [18:0] e;
    int ed;
    start();
    mem[12'h300] = 16'h1100;
    mem[12'h301] = 16'h5101;
    mem[12'h302] = 16'h2102;
    mem[12'h303] = 16'h0000;
    mem[12'h100] = a;
    mem[12'h101] = b;
    run(ed);
    e = sm_add(a, b);
    check(mem[12'h102] == e[15:0], "R5 add result", mem[12'h102], e[15:0]);
    check(psw == {1'b1, e[18], e[17], e[16]}, "R6 add flags", psw, {1'b1, e[18], e[17], e[16]});
    check(ed == 20 && wr_count == 1, "R2 R4 cycles/writes", ed, 20);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int ed;
    void'($urandom(32'd1234));

    start();
    @(negedge clk);
    check(mem_addr == 12'h300 && psw == 4'b1000 && !halted && !mem_we, "R1 reset state",
          {mem_addr, psw, halted, mem_we}, {12'h300, 4'b1000, 2'b00});

    start();
    mem[12'h300] = 16'h1940;
    mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941;
    mem[12'h303] = 16'h0000;
    mem[12'h940] = 16'h0003;
    mem[12'h941] = 16'h0002;
    run(ed);
    check(mem[12'h941] == 16'h0005, "R12 R3 sum stored", mem[12'h941], 16'h0005);
    check(ed == 20 && halted, "R12 R2 halt fetched at 0x303 after 4 instructions", ed, 20);
    for (int i = 0; i < 8; i++) @(negedge clk);
    check(halted && wr_count == 1, "R10 halt sticky, no writes", wr_count, 1);

    add_case(16'h0005, 16'h8005);
    add_case(16'h8000, 16'h8000);
    add_case(16'h7FFF, 16'h0001);
    add_case(16'hFFFF, 16'h8002);
    add_case(16'h8003, 16'h0001);
    add_case(16'h0001, 16'h8009);
    for (int k = 0; k < 40; k++) add_case(16'($urandom()), 16'($urandom()));

    start();
    mem[12'h300] = 16'h1100;
    mem[12'h301] = 16'h3ABC;
    mem[12'h302] = 16'h2102;
    mem[12'h303] = 16'h0000;
    mem[12'h100] = 16'h8005;
    run(ed);
    check(mem[12'h102] == 16'h8005, "R11 no-op keeps accumulator", mem[12'h102], 16'h8005);
    check(psw == 4'b1000, "R6 load/no-op keep flags", psw, 4'b1000);
    check(wr_count == 1 && mem[12'hABC] == 16'h0000, "R11 no-op writes nothing", wr_count, 1);

    start();
    mem[12'h300] = 16'h1100;
    mem[12'h301] = 16'h2103;
    mem[12'h302] = 16'h0000;
    mem[12'h100] = 16'h0007;
    mem[12'hFF0] = 16'h2200;
    mem[12'hFF1] = 16'hF000;
    irq = 1'b1;
    run(ed);
    check(mem[12'h200] == 16'h0007, "R7 handler ran from vector", mem[12'h200], 16'h0007);
    check(mem[12'h103] == 16'h0007, "R9 resumed program ran", mem[12'h103], 16'h0007);
    check(wr_count == 3, "R8 R9 entry count with irq held", wr_count, 3);
    check(ed == 35, "R8 R9 cycle count with irq held", ed, 35);
    check(psw[3] == 1'b1, "R9 enable restored", psw[3], 1);
    for (int i = 0; i < 8; i++) @(negedge clk);
    check(halted && wr_count == 3, "R10 irq ignored when halted", wr_count, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule